// File: doc/BRIEF.md
# Byte-Masked Random Data Fuzzer

This block corrupts selected bytes of a wide data word for fault-injection and robustness testing. Each input word arrives with a byte mask: every byte whose mask bit is set is XORed with a pseudo-random byte, and every other byte is passed through unchanged. A caller can therefore protect the fields that must stay intact, such as addresses, ports and checksums, and randomize only the payload fields it wants to stress.

The pseudo-random word is built from a row of narrow lanes, one per data byte. Each lane is a multiply-add (linear congruential) generator with its own increment and its own seed. A lane steps only when a word is accepted. The result is registered, so it appears one cycle after the input. A seed port can overwrite all lane states at once, which makes a run repeatable. The block carries no state machine: its only state is the set of lane registers and the output register.

Top module: `byte_fuzz_core`

## Requirements
- R1: While synchronous reset is high, out_valid is 0 and out_data is all zeros on the next clock edge. Reset loads lane i with the seed (37*i + 5) mod 256.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high. In cycles without a result, out_data holds its previous value.
- R3: Mask bit i controls data bits [8i+7:8i], with bit 0 controlling the least significant byte. A byte whose mask bit is 0 leaves the block equal to its input byte.
- R4: A byte whose mask bit is 1 leaves the block as its input byte XOR the state that lane i holds when the word is accepted.
- R5: On every accepted word, each lane steps as s_next = (141*s + 2*i + 1) mod 256. In a cycle without in_valid or seed_load, the lane states do not change.
- R6: When seed_load is high, lane i takes seed_data[8i+7:8i] at that clock edge. If in_valid is high in the same cycle, that word is fuzzed with the states held before the load, and the loaded seed replaces the step.
- R7: An all-zero mask returns the input word unchanged. An all-ones mask randomizes all 32 bytes.
- R8: After reset, the first word fuzzed with an all-ones mask and zero data contains 32 distinct byte values, because no two lanes share a seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word and mask are valid this cycle |
| in_data | input | 256 | Data word to be fuzzed |
| in_mask | input | 32 | Byte mask, one bit per data byte (1 = fuzz) |
| seed_load | input | 1 | Load all lane states from seed_data |
| seed_data | input | 256 | New lane states, byte i for lane i |
| out_valid | output | 1 | Fuzzed word is valid this cycle |
| out_data | output | 256 | Fuzzed word |

## Verification
The hardest case to reach from the ports is a cycle where a seed load and an accepted word meet. In that cycle the output must use the old lane states while the lanes take the new seed instead of stepping. The bench drives exactly that cycle right after a chain of steps, then follows it with an all-ones word so that the loaded states become visible at the output. Idle gaps are placed between words to show that lanes do not advance without input. A single-bit mask and an alternating mask show which lane feeds which byte.

// File: rtl/fuzz_pkg.sv
package fuzz_pkg;
    // Multiplier shared by all lanes; congruent to 1 mod 4 for full period
    localparam int LCG_MUL  = 141;
    // Seed spread across lanes; odd so lane seeds are distinct
    localparam int SEED_MUL = 37;
    localparam int SEED_OFS = 5;

    function automatic int lane_seed(input int idx, input int width);
        return (idx * SEED_MUL + SEED_OFS) % (1 << width);
    endfunction

    function automatic int lane_inc(input int idx, input int width);
        return (2 * idx + 1) % (1 << width);
    endfunction
endpackage

// File: rtl/fuzz_mask_expand.sv
module fuzz_mask_expand #(
    parameter int LANES  = 32,
    parameter int LANE_W = 8
) (
    input  logic [LANES-1:0]        mask,
    output logic [LANES*LANE_W-1:0] mask_wide
);
    for (genvar g = 0; g < LANES; g++) begin : g_byte
        assign mask_wide[g*LANE_W +: LANE_W] = {LANE_W{mask[g]}};
    end
endmodule

// File: rtl/fuzz_lcg_lane.sv
module fuzz_lcg_lane #(
    parameter int LANE_W = 8,
    parameter int MUL    = 141,
    parameter int INC    = 1,
    parameter int SEED   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              load,
    input  logic [LANE_W-1:0] load_val,
    output logic [LANE_W-1:0] state
);
    localparam logic [LANE_W-1:0] MUL_C  = LANE_W'(MUL);
    localparam logic [LANE_W-1:0] INC_C  = LANE_W'(INC);
    localparam logic [LANE_W-1:0] SEED_C = LANE_W'(SEED);

    logic [LANE_W-1:0] nxt;

    always_comb begin
        nxt = LANE_W'(state * MUL_C + INC_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED_C;
        end else if (load) begin
            state <= load_val;
        end else if (step) begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/fuzz_xor_stage.sv
module fuzz_xor_stage #(
    parameter int WIDTH = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic [WIDTH-1:0] rand_i,
    input  logic [WIDTH-1:0] mask_wide_i,
    output logic             vld_o,
    output logic [WIDTH-1:0] data_o
);
    logic [WIDTH-1:0] flip;
    logic [WIDTH-1:0] fuzzed;

    always_comb begin
        flip   = rand_i & mask_wide_i;
        fuzzed = data_i ^ flip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            data_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                data_o <= fuzzed;
            end
        end
    end
endmodule

// File: rtl/byte_fuzz_core.sv
module byte_fuzz_core #(
    parameter int LANES  = 32,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LANES*LANE_W-1:0] in_data,
    input  logic [LANES-1:0]        in_mask,
    input  logic                    seed_load,
    input  logic [LANES*LANE_W-1:0] seed_data,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_data
);
    localparam int WIDTH = LANES * LANE_W;

    logic [WIDTH-1:0] rand_word;
    logic [WIDTH-1:0] mask_wide;

    fuzz_mask_expand #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_expand (
        .mask      (in_mask),
        .mask_wide (mask_wide)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fuzz_lcg_lane #(
            .LANE_W (LANE_W),
            .MUL    (fuzz_pkg::LCG_MUL),
            .INC    (fuzz_pkg::lane_inc(g, LANE_W)),
            .SEED   (fuzz_pkg::lane_seed(g, LANE_W))
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .step     (in_valid),
            .load     (seed_load),
            .load_val (seed_data[g*LANE_W +: LANE_W]),
            .state    (rand_word[g*LANE_W +: LANE_W])
        );
    end

    fuzz_xor_stage #(
        .WIDTH (WIDTH)
    ) u_xor (
        .clk         (clk),
        .rst         (rst),
        .vld_i       (in_valid),
        .data_i      (in_data),
        .rand_i      (rand_word),
        .mask_wide_i (mask_wide),
        .vld_o       (out_valid),
        .data_o      (out_data)
    );
endmodule

// File: rtl/byte_fuzz_sva.sv
module byte_fuzz_sva #(
    parameter int LANES  = 32,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [LANES*LANE_W-1:0] in_data,
    input logic [LANES-1:0]        in_mask,
    input logic                    out_valid,
    input logic [LANES*LANE_W-1:0] out_data
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0)); // R1
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_data)); // R2
    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mask == '0) |=> out_data == $past(in_data)); // R7

    for (genvar g = 0; g < LANES; g++) begin : g_keep
        AST_KEEP_BYTE: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !in_mask[g]) |=>
            out_data[g*LANE_W +: LANE_W] == $past(in_data[g*LANE_W +: LANE_W])); // R3
    end
endmodule

bind byte_fuzz_core byte_fuzz_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_mask   (in_mask),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/byte_fuzz_core_tb.sv
module byte_fuzz_core_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [255:0] in_data = '0;
    logic [31:0]  in_mask = '0;
    logic         seed_load = 1'b0;
    logic [255:0] seed_data = '0;
    logic         out_valid;
    logic [255:0] out_data;

    int checks = 0;
    int failures = 0;

    logic [255:0] exp_q[$];
    string        tag_q[$];
    logic [7:0]   model[32];
    logic [255:0] last_out = '0;
    logic [255:0] hold_val = '0;

    always #4 clk = ~clk;

    byte_fuzz_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_mask   (in_mask),
        .seed_load (seed_load),
        .seed_data (seed_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One driven cycle; expected result from the lane model (R4, R5, R6)
    task automatic drive(input bit v, input logic [255:0] d, input logic [31:0] m,
                         input bit ld, input logic [255:0] sd, input string tag);
        logic [255:0] e;
        @(negedge clk);
        in_valid  = v;
        in_data   = d;
        in_mask   = m;
        seed_load = ld;
        seed_data = sd;
        for (int i = 0; i < 32; i++) begin
            e[i*8 +: 8] = d[i*8 +: 8] ^ (m[i] ? model[i] : 8'h00);
        end
        for (int i = 0; i < 32; i++) begin
            if (ld) model[i] = sd[i*8 +: 8];
            else if (v) model[i] = 8'(model[i] * 8'd141 + 8'(2*i + 1));
        end
        if (v) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, '0, '0, 1'b0, '0, "");
    endtask

    function automatic logic [255:0] rnd256();
        return {$urandom(), $urandom(), $urandom(), $urandom(),
                $urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected out_valid", out_data, '0);
                end else begin
                    logic [255:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data === e, t, out_data, e);
                end
                last_out = out_data;
            end else begin
                check(out_data === hold_val, "R2 hold while idle", out_data, hold_val);
            end
            hold_val = out_data;
        end
    end

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired actual=hung expected=done");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        join_none

        for (int i = 0; i < 32; i++) model[i] = 8'((37*i + 5) % 256);

        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid in reset", {255'd0, out_valid}, '0);
        check(out_data === '0, "R1 out_data in reset", out_data, '0);
        @(negedge clk);
        rst = 1'b0;
        hold_val = out_data;

        // R8/R1: first all-ones word on zero data exposes the seeds
        drive(1'b1, '0, 32'hFFFF_FFFF, 1'b0, '0, "R1 seeds visible");
        idle(2);
        begin
            bit uniq = 1'b1;
            for (int a = 0; a < 32; a++)
                for (int b = a + 1; b < 32; b++)
                    if (last_out[a*8 +: 8] == last_out[b*8 +: 8]) uniq = 1'b0;
            check(uniq, "R8 distinct lane bytes", last_out, '0);
        end

        // R7 all-zero mask, several patterns
        drive(1'b1, rnd256(), 32'h0, 1'b0, '0, "R7 zero mask");
        drive(1'b1, {32{8'hA5}}, 32'h0, 1'b0, '0, "R7 zero mask");
        drive(1'b1, rnd256(), 32'hFFFF_FFFF, 1'b0, '0, "R7 all-ones mask");
        // R3 byte order: only the lowest / highest byte
        drive(1'b1, rnd256(), 32'h0000_0001, 1'b0, '0, "R3 mask bit0");
        drive(1'b1, rnd256(), 32'h8000_0000, 1'b0, '0, "R3 mask bit31");
        drive(1'b1, rnd256(), 32'hAAAA_AAAA, 1'b0, '0, "R4 alternating mask");
        // R5: idle gap must not advance lanes
        idle(5);
        drive(1'b1, '0, 32'hFFFF_FFFF, 1'b0, '0, "R5 after idle gap");
        // R6: seed load alone, then observe
        drive(1'b0, '0, '0, 1'b1, {32{8'h3C}}, "");
        idle(1);
        drive(1'b1, '0, 32'hFFFF_FFFF, 1'b0, '0, "R6 loaded seed");
        // R6: seed load together with a word
        drive(1'b1, rnd256(), 32'h0F0F_F0F0, 1'b1, rnd256(), "R6 concurrent load uses old state");
        drive(1'b1, '0, 32'hFFFF_FFFF, 1'b0, '0, "R6 state after concurrent load");
        // R5 back-to-back stream
        for (int k = 0; k < 24; k++)
            drive(1'b1, rnd256(), $urandom(), 1'b0, '0, "R5 stream");
        idle(3);

        check(exp_q.size() == 0, "R2 all results delivered", 256'(exp_q.size()), '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule